// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Generator

This block is the interrupt collector shared by the two channels of a dual serial controller. Each channel reports four kinds of cause: transmit buffer empty, a change on its external or status inputs, a received character, and a special receive condition (overrun, framing, or parity when the mode counts parity). Each cause is latched and then gated by that channel's enables and its receive interrupt mode. The block picks a single winner by fixed priority and drives an interrupt request. That request also serves as the pending flag that software reads through channel A's status.

Software keeps one 8-bit base vector for both channels. It writes and reads that vector through channel B's register path. When the status-affects-vector option is on, vector bits 3:1 are replaced by a code that names the winning channel and cause. Enables, receive modes and the option bit come from the channel register files. The command port carries the per-channel reset commands for clearing latched causes. The acknowledge cycle and daisy chaining are handled elsewhere.

Top module: `dual_irq_vector`

## Requirements
- R1: A write on `vec_wr` stores `vec_wdata` as the base vector, and it is readable from the next cycle. With `sav`=0, `vec_rdata` equals the base unchanged. With `sav`=1, bits 7:4 and bit 0 still equal the base. After reset the base is 0.
- R2: With `sav`=1, `vec_rdata[3:1]` holds the winner's code. The codes are 0 for B transmit, 1 for B external, 2 for B receive available, 3 for B special, 4 for A transmit, 5 for A external, 6 for A receive available and 7 for A special.
- R3: When no gated request is active, `irq` is 0 and, with `sav`=1, the code field reads 3'b011.
- R4: A `tx_evt` pulse latches a transmit cause for that channel. It requests only while that channel's `tx_en` bit is 1 and stays latched through enable changes. It clears only on command code 5 addressed to that channel. Channel index 1 is A and index 0 is B, for every 2-bit port and for `cmd_chan`.
- R5: An `ext_evt` pulse latches an external/status cause. It is gated by `ext_en` and cleared only by command code 2 addressed to that channel.
- R6: On an `rx_char` pulse with `rx_ovr` or `rx_frm` set, a special cause is latched if the channel's mode is nonzero. In mode 2 `rx_par` also makes the character special. A special cause clears on command code 6 for that channel.
- R7: In modes 2 and 3, a character without a special condition latches a receive-available cause. In mode 3 a parity error does not make a character special. The receive-available cause clears on that channel's `rx_read` pulse.
- R8: In mode 1, only the first character after arming latches a receive-available cause. Arming happens on command code 4 for that channel, or when the channel's mode changes to 1. Later characters are ignored until the next arming.
- R9: In mode 0 (`rx_mode` field 2'b00; A uses bits 3:2 and B uses bits 1:0) the channel raises no receive request.
- R10: Priority from highest to lowest is A special, A available, A transmit, A external, B special, B available, B transmit, B external.
- R11: `irq` is 1 exactly when at least one gated request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_wr | input | 1 | Base vector write strobe |
| vec_wdata | input | 8 | Base vector write data |
| sav | input | 1 | Status affects vector (channel B option) |
| tx_en | input | 2 | Transmit interrupt enables [A,B] |
| ext_en | input | 2 | External/status interrupt enables [A,B] |
| rx_mode | input | 4 | Receive interrupt modes, A in 3:2, B in 1:0 |
| tx_evt | input | 2 | Transmit buffer became empty pulses |
| ext_evt | input | 2 | External/status change pulses |
| rx_char | input | 2 | Character received pulses |
| rx_par | input | 2 | Parity error qualifier for rx_char |
| rx_ovr | input | 2 | Overrun qualifier for rx_char |
| rx_frm | input | 2 | Framing error qualifier for rx_char |
| rx_read | input | 2 | Receive data read pulses |
| cmd_valid | input | 1 | Command strobe |
| cmd_chan | input | 1 | Command target channel (1=A) |
| cmd_code | input | 3 | Command code (2,4,5,6 act) |
| irq | output | 1 | Interrupt request / pending flag |
| vec_rdata | output | 8 | Vector as read back |

## Verification
The assertions assume that the event inputs are single-cycle pulses sampled on the rising edge. They also assume that the enables and modes hold steady between the edges where they change. The reset behaviour they rely on is a low `rst_n` that leaves the base vector at zero. The bench drives every input just after a falling edge and holds it until the next one, so all of these hold. Random rounds vary the modes only rarely, so that first-character arming and its consumption both show up often. Directed rounds keep any arming on a separate cycle from the character that consumes it.

// File: rtl/dual_irq_vector.sv
`timescale 1ns/1ps
module dual_irq_vector (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vec_wr,
  input  logic [7:0] vec_wdata,
  input  logic       sav,
  input  logic [1:0] tx_en,
  input  logic [1:0] ext_en,
  input  logic [3:0] rx_mode,
  input  logic [1:0] tx_evt,
  input  logic [1:0] ext_evt,
  input  logic [1:0] rx_char,
  input  logic [1:0] rx_par,
  input  logic [1:0] rx_ovr,
  input  logic [1:0] rx_frm,
  input  logic [1:0] rx_read,
  input  logic       cmd_valid,
  input  logic       cmd_chan,
  input  logic [2:0] cmd_code,
  output logic       irq,
  output logic [7:0] vec_rdata
);
  logic [7:0] base;
  logic [1:0] tx_req, ext_req, av_req, sp_req;
  logic [2:0] code;

  always_ff @(posedge clk)
    if (!rst_n) base <= '0;
    else if (vec_wr) base <= vec_wdata;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    wire [1:0] m     = rx_mode[2*c+1:2*c];
    wire       here  = cmd_valid && (cmd_chan == 1'(c));
    wire       err   = rx_ovr[c] | rx_frm[c] | (rx_par[c] && m == 2'd2);
    logic       txp, exq, avp, spp, armed;
    logic [1:0] mq;
    wire       arm   = (here && cmd_code == 3'd4) || (m == 2'd1 && mq != 2'd1);
    wire       sp_set = rx_char[c] && err && m != 2'd0;
    wire       av_set = rx_char[c] && !err && (m[1] || (m == 2'd1 && armed));

    always_ff @(posedge clk)
      if (!rst_n) begin
        txp <= 1'b0; exq <= 1'b0; avp <= 1'b0; spp <= 1'b0;
        armed <= 1'b0; mq <= 2'd0;
      end else begin
        txp   <= tx_evt[c]  | (txp & ~(here && cmd_code == 3'd5));
        exq   <= ext_evt[c] | (exq & ~(here && cmd_code == 3'd2));
        spp   <= sp_set     | (spp & ~(here && cmd_code == 3'd6));
        avp   <= av_set     | (avp & ~rx_read[c]);
        mq    <= m;
        armed <= arm ? 1'b1 : (rx_char[c] ? 1'b0 : armed);
      end

    assign tx_req[c]  = txp & tx_en[c];
    assign ext_req[c] = exq & ext_en[c];
    assign av_req[c]  = avp & (m != 2'd0);
    assign sp_req[c]  = spp & (m != 2'd0);
  end

  always_comb begin
    code = 3'b011;
    if (ext_req[0]) code = 3'd1;
    if (tx_req[0])  code = 3'd0;
    if (av_req[0])  code = 3'd2;
    if (sp_req[0])  code = 3'd3;
    if (ext_req[1]) code = 3'd5;
    if (tx_req[1])  code = 3'd4;
    if (av_req[1])  code = 3'd6;
    if (sp_req[1])  code = 3'd7;
  end

  assign irq       = |{tx_req, ext_req, av_req, sp_req};
  assign vec_rdata = sav ? {base[7:4], code, base[0]} : base;
endmodule

// File: rtl/dual_irq_vector_chk.sv
`timescale 1ns/1ps
module dual_irq_vector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       vec_wr,
  input logic [7:0] vec_wdata,
  input logic       sav,
  input logic [1:0] tx_en,
  input logic [1:0] ext_en,
  input logic [3:0] rx_mode,
  input logic [1:0] tx_evt,
  input logic       irq,
  input logic [7:0] vec_rdata
);
  assert_vec_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vec_wr) && !sav) |-> vec_rdata == $past(vec_wdata));

  assert_upper_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vec_wr) |-> {vec_rdata[7:4], vec_rdata[0]} == {$past(vec_wdata[7:4]), $past(vec_wdata[0])});

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sav && !irq) |-> vec_rdata[3:1] == 3'b011);

  assert_tx_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt[1] && tx_en[1]) |=> (irq || !tx_en[1]));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en == 2'b00 && ext_en == 2'b00 && rx_mode == 4'd0) |-> !irq);
endmodule

bind dual_irq_vector dual_irq_vector_chk u_chk (.*);

// File: tb/sim_dual_irq_vector.sv
`timescale 1ns/1ps
module sim_dual_irq_vector;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       vec_wr = 0, sav = 0, cmd_valid = 0, cmd_chan = 0;
  logic [7:0] vec_wdata = 0;
  logic [1:0] tx_en = 0, ext_en = 0, tx_evt = 0, ext_evt = 0, rx_char = 0;
  logic [1:0] rx_par = 0, rx_ovr = 0, rx_frm = 0, rx_read = 0;
  logic [3:0] rx_mode = 0;
  logic [2:0] cmd_code = 0;
  logic       irq;
  logic [7:0] vec_rdata;

  dual_irq_vector u0 (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  bit       mtx[2], mex[2], mav[2], msp[2], marm[2];
  bit [1:0] mq[2];
  bit [7:0] mbase;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [1:0] mode_of(int c);
    return c ? rx_mode[3:2] : rx_mode[1:0];
  endfunction

  function automatic bit [3:0] mcode();
    bit [3:0] r = 4'h8;
    for (int c = 0; c < 2; c++) begin
      bit on = mode_of(c) != 0;
      if (mex[c] && ext_en[c]) r = c ? 4'd5 : 4'd1;
      if (mtx[c] && tx_en[c])  r = c ? 4'd4 : 4'd0;
      if (mav[c] && on)        r = c ? 4'd6 : 4'd2;
      if (msp[c] && on)        r = c ? 4'd7 : 4'd3;
    end
    return r;
  endfunction

  task automatic mtick();
    if (vec_wr) mbase = vec_wdata;
    for (int c = 0; c < 2; c++) begin
      bit [1:0] m = mode_of(c);
      bit here = cmd_valid && cmd_chan == c[0];
      bit err = rx_ovr[c] || rx_frm[c] || (rx_par[c] && m == 2);
      bit first = m == 1 && marm[c];
      bit arm = (here && cmd_code == 4) || (m == 1 && mq[c] != 1);
      if (here && cmd_code == 5) mtx[c] = 0;
      if (here && cmd_code == 2) mex[c] = 0;
      if (here && cmd_code == 6) msp[c] = 0;
      if (rx_read[c]) mav[c] = 0;
      if (tx_evt[c]) mtx[c] = 1;
      if (ext_evt[c]) mex[c] = 1;
      if (rx_char[c] && err && m != 0) msp[c] = 1;
      if (rx_char[c] && !err && (m >= 2 || first)) mav[c] = 1;
      if (arm) marm[c] = 1; else if (rx_char[c]) marm[c] = 0;
      mq[c] = m;
    end
  endtask

  task automatic step();
    bit [3:0] k;
    @(posedge clk);
    if (rst_n) mtick();
    @(negedge clk);
    if (rst_n) begin
      k = mcode();
      check("R11 model irq", {7'd0, irq}, {7'd0, !k[3]});
      check("R2 model vector", vec_rdata,
            sav ? {mbase[7:4], (k[3] ? 3'b011 : k[2:0]), mbase[0]} : mbase);
    end
    vec_wr = 0; tx_evt = 0; ext_evt = 0; rx_char = 0; rx_par = 0;
    rx_ovr = 0; rx_frm = 0; rx_read = 0; cmd_valid = 0;
  endtask

  task automatic cmd(bit ch, bit [2:0] cd);
    cmd_valid = 1; cmd_chan = ch; cmd_code = cd; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset irq", {7'd0, irq}, 8'd0);
    check("R1 reset base", vec_rdata, 8'h00);
    rst_n = 1;
    step();

    vec_wr = 1; vec_wdata = 8'h5A; step();
    check("R1 base readback", vec_rdata, 8'h5A);
    sav = 1; step();
    check("R3 idle code", vec_rdata, 8'h56);
    check("R3 idle irq", {7'd0, irq}, 8'd0);

    tx_en = 2'b01; tx_evt = 2'b01; step();
    check("R4 B tx vector", vec_rdata, 8'h50);
    tx_en = 2'b00; step();
    check("R4 gated off", {7'd0, irq}, 8'd0);
    tx_en = 2'b01; step();
    check("R4 still latched", {7'd0, irq}, 8'd1);
    cmd(1'b1, 3'd5);
    check("R4 other channel no clear", {7'd0, irq}, 8'd1);
    cmd(1'b0, 3'd5);
    check("R4 cleared", {7'd0, irq}, 8'd0);

    ext_en = 2'b10; ext_evt = 2'b10; step();
    check("R5 A ext vector", vec_rdata, 8'h5A);
    cmd(1'b1, 3'd2);
    check("R5 cleared", {7'd0, irq}, 8'd0);

    rx_mode = 4'b0010; tx_en = 2'b10; step();
    rx_char = 2'b01; tx_evt = 2'b10; step();
    check("R10 A tx over B avail", vec_rdata, 8'h58);
    cmd(1'b1, 3'd5);
    check("R10 B avail next", vec_rdata, 8'h54);
    rx_read = 2'b01; step();
    check("R7 read clears", {7'd0, irq}, 8'd0);

    rx_mode = 4'b1010; step();
    rx_char = 2'b10; rx_par = 2'b10; step();
    check("R6 parity special A", vec_rdata, 8'h5E);
    rx_char = 2'b01; rx_frm = 2'b01; step();
    check("R10 A special over B special", vec_rdata, 8'h5E);
    cmd(1'b1, 3'd6);
    check("R6 B framing special", vec_rdata, 8'h56);
    check("R6 B special irq", {7'd0, irq}, 8'd1);
    cmd(1'b0, 3'd6);
    check("R6 cleared", {7'd0, irq}, 8'd0);

    rx_mode = 4'b1110; step();
    rx_char = 2'b10; rx_par = 2'b10; step();
    check("R7 mode3 parity as avail", vec_rdata, 8'h5C);
    rx_read = 2'b10; step();

    rx_mode = 4'b1101; step();
    rx_char = 2'b01; step();
    check("R8 first char", vec_rdata, 8'h54);
    rx_read = 2'b01; step();
    rx_char = 2'b01; step();
    check("R8 second char ignored", {7'd0, irq}, 8'd0);
    cmd(1'b0, 3'd4);
    rx_char = 2'b01; step();
    check("R8 rearmed", vec_rdata, 8'h54);
    rx_read = 2'b01; step();

    rx_mode = 4'b0001; step();
    rx_char = 2'b10; rx_ovr = 2'b10; step();
    check("R9 mode0 no request", {7'd0, irq}, 8'd0);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      if (r < 3) rx_mode = 4'($urandom);
      if (r >= 3 && r < 6) begin tx_en = 2'($urandom); ext_en = 2'($urandom); end
      if (r >= 6 && r < 8) sav = ~sav;
      if (r >= 8 && r < 10) begin vec_wr = 1; vec_wdata = 8'($urandom); end
      if ($urandom % 6 == 0) tx_evt = 2'($urandom);
      if ($urandom % 6 == 0) ext_evt = 2'($urandom);
      if ($urandom % 4 == 0) begin
        rx_char = 2'($urandom);
        if ($urandom % 3 == 0) rx_par = 2'($urandom);
        if ($urandom % 5 == 0) rx_ovr = 2'($urandom);
        if ($urandom % 5 == 0) rx_frm = 2'($urandom);
      end
      if ($urandom % 5 == 0) rx_read = 2'($urandom);
      if ($urandom % 4 == 0) begin
        cmd_valid = 1; cmd_chan = 1'($urandom); cmd_code = 3'($urandom);
      end
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule